// File: doc/BRIEF.md
# Interleaved Board Address Matcher

This block sits on a memory board and decides, for every word address on the system bus, whether that word lives on this board. Software programs a 16-bit match register that holds four things: a disable flag that takes the board off the bus, a region number, a slot number inside an interleave group, and an interleave mode. In 1-way mode the board owns one contiguous region of 2^18 words. In 2-, 4- or 8-way mode, consecutive word addresses rotate across the boards of a group. The low word-address bits then pick the board, and the region number is narrowed by the same number of bits.

On a match the block raises a select signal and presents the 18-bit physical word address on the board. The address is split into a 9-bit row half and a 9-bit column half, which the DRAM sequencer sends out in that order. Selection and the row/column split are combinational from the address. A registered copy of select, row and column follows one clock later for a pipelined controller.

Top module: `board_addr_match`

## Requirements
- R1: After reset the match register reads 0x0001: mode 000, region 0, slot 0 and the disable flag set. Both the combinational and the registered select outputs are low.
- R2: While register bit 0 (disable) is 1, select is never asserted, whatever the address.
- R3: In mode 000, select is high exactly when word_addr[26:18] equals the region field. The physical address is then word_addr[17:0].
- R4: In modes 001, 010 and 011 (N = 2, 4, 8; k = 1, 2, 3), select is high exactly when word_addr[k-1:0] equals slot[k-1:0] and word_addr[26:18+k] equals region[8:k]. The physical address is then word_addr[17+k:k].
- R5: In a k-way mode, slot bits above k-1 and region bits below k have no effect on selection or on the physical address.
- R6: Mode codes 100 to 111 never select.
- R7: row_o carries physical bits [17:9] and col_o carries bits [8:0]. Both are zero whenever select is low.
- R8: sel_q_o, row_q_o and col_q_o equal the values that sel_o, row_o and col_o had on the previous clock. All three reset to zero.
- R9: In 1-, 2-, 4- and 8-way mode, take N boards that share a mode and region and hold slots 0 to N-1. Every word address inside the region is selected by exactly one of them.
- R10: The match register layout is [15:13] mode, [12:4] region, [3:1] slot, [0] disable. A rising clock edge with cfg_we high loads cfg_wdata, and without cfg_we the register holds. cfg_rdata always shows the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Match register write enable |
| cfg_wdata | input | 16 | Match register write value |
| cfg_rdata | output | 16 | Current match register contents |
| word_addr | input | 27 | Logical word address from the bus |
| sel_o | output | 1 | Board selected (combinational) |
| row_o | output | 9 | Physical row half (combinational) |
| col_o | output | 9 | Physical column half (combinational) |
| sel_q_o | output | 1 | Registered select |
| row_q_o | output | 9 | Registered row half |
| col_q_o | output | 9 | Registered column half |

## Verification
The assertions assume that word_addr, cfg_we and cfg_wdata carry known values from the end of reset on. They also assume these inputs change only away from the rising edge, so the registered copy and the register write see one settled value per cycle. The stimulus holds reset for several cycles with every input driven to zero, and changes inputs only on the falling edge. Each address is held for one full cycle, so the pipelined outputs can be compared against the combinational result of the cycle before.

// File: rtl/board_match_pkg.sv
`timescale 1ns/1ps
package board_match_pkg;
    localparam int WA_W    = 27;
    localparam int ROW_W   = 9;
    localparam int COL_W   = 9;
    localparam int PHYS_W  = ROW_W + COL_W;
    localparam int GRP_W   = WA_W - PHYS_W;
    localparam int MAX_K   = 3;
    localparam int SLOT_W  = MAX_K;
    localparam int NUM_K   = MAX_K + 1;
    localparam int KSEL_W  = $clog2(NUM_K);
    localparam int MODE_W  = 3;
    localparam int CFG_W   = MODE_W + GRP_W + SLOT_W + 1;

    typedef enum logic [MODE_W-1:0] {
        ILV_ONE   = 3'd0,
        ILV_TWO   = 3'd1,
        ILV_FOUR  = 3'd2,
        ILV_EIGHT = 3'd3
    } ilv_mode_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [GRP_W-1:0]  region;
        logic [SLOT_W-1:0] slot;
        logic              off;
    } match_cfg_t;

    typedef struct packed {
        logic             hit;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } match_out_t;

    localparam match_cfg_t CFG_RESET = '{mode: ILV_ONE, region: '0, slot: '0, off: 1'b1};
endpackage

// File: rtl/board_cfg_reg.sv
`timescale 1ns/1ps
module board_cfg_reg
    import board_match_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output match_cfg_t       cfg_o
);
    match_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = match_cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R10
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == match_cfg_t'($past(wdata))));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/board_addr_decode.sv
`timescale 1ns/1ps
module board_addr_decode
    import board_match_pkg::*;
(
    input  logic [WA_W-1:0]  wa,
    input  match_cfg_t       cfg,
    output logic             hit,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    logic [NUM_K-1:0]  cand_hit;
    logic [PHYS_W-1:0] cand_phys [NUM_K];
    logic [PHYS_W-1:0] phys;
    logic              mode_ok;

    // One candidate per interleave width: k low address bits pick the slot,
    // the region compare narrows by k bits, the physical word shifts by k.
    for (genvar k = 0; k < NUM_K; k++) begin : g_way
        localparam logic [SLOT_W-1:0] SLOT_MASK = SLOT_W'((1 << k) - 1);
        logic slot_ok;
        logic grp_ok;
        assign slot_ok      = ((wa[SLOT_W-1:0] ^ cfg.slot) & SLOT_MASK) == '0;
        assign grp_ok       = (wa[WA_W-1:PHYS_W] >> k) == (cfg.region >> k);
        assign cand_hit[k]  = slot_ok && grp_ok;
        assign cand_phys[k] = PHYS_W'(wa >> k);
    end

    assign mode_ok = cfg.mode < MODE_W'(NUM_K);

    always_comb begin
        hit  = 1'b0;
        phys = '0;
        if (!cfg.off && mode_ok && cand_hit[cfg.mode[KSEL_W-1:0]]) begin
            hit  = 1'b1;
            phys = cand_phys[cfg.mode[KSEL_W-1:0]];
        end
    end

    assign row = phys[PHYS_W-1:COL_W];
    assign col = phys[COL_W-1:0];
endmodule

// File: rtl/board_addr_match.sv
`timescale 1ns/1ps
module board_addr_match
    import board_match_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    input  logic [26:0]      word_addr,
    output logic             sel_o,
    output logic [8:0]       row_o,
    output logic [8:0]       col_o,
    output logic             sel_q_o,
    output logic [8:0]       row_q_o,
    output logic [8:0]       col_q_o
);
    match_cfg_t cfg;
    logic             hit_c;
    logic [ROW_W-1:0] row_c;
    logic [COL_W-1:0] col_c;
    match_out_t out_d, out_q;

    board_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    board_addr_decode u_dec (
        .wa  (word_addr),
        .cfg (cfg),
        .hit (hit_c),
        .row (row_c),
        .col (col_c)
    );

    always_comb begin
        out_d     = out_q;
        out_d.hit = hit_c;
        out_d.row = row_c;
        out_d.col = col_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cfg_rdata = cfg;
    assign sel_o     = hit_c;
    assign row_o     = row_c;
    assign col_o     = col_c;
    assign sel_q_o   = out_q.hit;
    assign row_q_o   = out_q.row;
    assign col_q_o   = out_q.col;

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.off |-> !sel_o);

    // R6
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode >= MODE_W'(NUM_K)) |-> !sel_o);

    // R4
    two_way_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && cfg.mode == ILV_TWO) |-> (word_addr[0] == cfg.slot[0]));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_o |-> (row_o == '0 && col_o == '0));

    // R8
    sel_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q_o == $past(sel_o));

    // R8
    addr_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {row_q_o, col_q_o} == $past({row_o, col_o}));
endmodule

// File: tb/board_addr_match_test.sv
`timescale 1ns/1ps
module board_addr_match_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [26:0] word_addr = '0;
    logic        sel, sel_q;
    logic [8:0]  row, col, row_q, col_q;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [15:0] cur_cfg = 16'h0001;

    always #2.5 clk = ~clk;

    board_addr_match uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .word_addr(word_addr),
        .sel_o(sel), .row_o(row), .col_o(col),
        .sel_q_o(sel_q), .row_q_o(row_q), .col_q_o(col_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkcfg(input int m, input int g, input int s, input bit off);
        return {m[2:0], g[8:0], s[2:0], off};
    endfunction

    // Behavioural model: slot = addr mod N, region = addr / (N * 2^18), word = (addr / N) mod 2^18
    function automatic void model(input logic [15:0] c, input logic [26:0] a,
                                  output bit h, output int unsigned ph);
        int unsigned m, n, wa, sl, g;
        m  = 32'(c[15:13]);
        wa = 32'(a);
        h  = 1'b0;
        ph = 0;
        if (c[0] || m > 3) return;
        n  = 1 << m;
        sl = wa % n;
        g  = wa / (n * 262144);
        if (sl == (32'(c[3:1]) % n) && g == (32'(c[12:4]) / n)) begin
            h  = 1'b1;
            ph = (wa / n) % 262144;
        end
    endfunction

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #1;
        cfg_we  = 1'b0;
        cur_cfg = v;
        chk("R10 readback", 32'(cfg_rdata), 32'(v));
    endtask

    task automatic step(input logic [26:0] a, input string req, output bit h);
        bit eh;
        int unsigned ep;
        @(negedge clk);
        word_addr = a;
        #1;
        model(cur_cfg, a, eh, ep);
        chk({req, " sel"}, 32'(sel), 32'(eh));
        chk({req, " row R7"}, 32'(row), ep / 512);
        chk({req, " col R7"}, 32'(col), ep % 512);
        h = sel;
        @(posedge clk);
        #1;
        chk({req, " sel_q R8"}, 32'(sel_q), 32'(eh));
        chk({req, " row_q R8"}, 32'(row_q), ep / 512);
        chk({req, " col_q R8"}, 32'(col_q), ep % 512);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit h;
        int cnt [32];
        logic [26:0] base;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 cfg reset", 32'(cfg_rdata), 32'h0001);
        chk("R1 sel reset", 32'(sel), 0);
        chk("R1 sel_q reset", 32'(sel_q), 0);

        // R2 disabled board: region 0 addresses would match otherwise
        step(27'd0, "R2", h);
        chk("R2 no select at reset cfg", 32'(h), 0);
        write_cfg(mkcfg(2, 'h0A5, 1, 1'b1));
        for (int i = 0; i < 8; i++) begin
            step((27'h0A5 << 18) + 27'(i), "R2", h);
            chk("R2 disabled", 32'(h), 0);
        end

        // R3 one-way region decode
        write_cfg(mkcfg(0, 'h0A5, 5, 1'b0));
        step((27'h0A5 << 18), "R3", h);
        chk("R3 region start", 32'(h), 1);
        step((27'h0A5 << 18) + 27'h3FFFF, "R3", h);
        chk("R3 region end", 32'(h), 1);
        step((27'h0A6 << 18), "R3", h);
        chk("R3 next region", 32'(h), 0);
        step((27'h0A4 << 18) + 27'h3FFFF, "R3", h);
        chk("R3 prev region", 32'(h), 0);
        step((27'h0A5 << 18) + 27'h2A5C3, "R7", h);

        // R4 / R9 sweeps over each interleave width
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 32; i++) cnt[i] = 0;
            base = 27'h0A5 << 18;
            for (int s = 0; s < (1 << k); s++) begin
                write_cfg(mkcfg(k, 'h0A5, s, 1'b0));
                for (int i = 0; i < 32; i++) begin
                    step(base + 27'(i), "R4", h);
                    if (h) cnt[i]++;
                end
            end
            for (int i = 0; i < 32; i++) chk("R9 one owner", 32'(cnt[i]), 1);
        end

        // R5 ignored slot and region bits in two-way mode
        write_cfg(mkcfg(1, 'h0A4, 7, 1'b0));
        step((27'h0A5 << 18) + 27'd1, "R5", h);
        chk("R5 odd word owned", 32'(h), 1);
        step((27'h0A5 << 18) + 27'd2, "R5", h);
        chk("R5 even word not owned", 32'(h), 0);
        write_cfg(mkcfg(3, 'h0A0, 3, 1'b0));
        step((27'h0A7 << 18) + 27'd3, "R5", h);
        chk("R5 eight-way low region bits", 32'(h), 1);

        // R6 reserved modes
        for (int m = 4; m < 8; m++) begin
            write_cfg(mkcfg(m, 'h0A5, 0, 1'b0));
            for (int i = 0; i < 4; i++) begin
                step((27'h0A5 << 18) + 27'(i * 8), "R6", h);
                chk("R6 reserved mode", 32'(h), 0);
            end
        end

        // Mixed patterns against the model
        for (int r = 0; r < 10; r++) begin
            int g;
            g = int'($urandom % 512);
            write_cfg(mkcfg(int'($urandom % 5), g, int'($urandom % 8), ($urandom % 6) == 0));
            for (int i = 0; i < 20; i++) begin
                logic [26:0] a;
                a = 27'($urandom);
                if (i % 2 == 0) a = (27'(g) << 18) | (a & 27'h3FFFF);
                step(a, "R4", h);
            end
        end

        finish_run();
    end
endmodule